// File: doc/BRIEF.md
# Dual-Mode Character Memory Writer

This block accepts character codes from a processor bus and stores them in a small display memory of eight 6-bit entries. Entry 0 is the leftmost character. A display scanner reads the memory through a separate combinational read port. The scanner is not part of this block, and neither are the glyph lookup or the output drivers.

A write is framed by an effective strobe. That strobe is active when the active-low write line is low, the active-high select is high and the active-low select is low. The mode, the address and the serial enable are captured when the strobe turns on. The data is captured when the strobe turns off.

The block has two addressing modes:

- **Random mode:** three address lines choose the entry. Address and data may therefore share one bus.
- **Sequential mode:** an internal counter fills the entries from left to right. A full flag stops further entries, so that several units can be chained.

In sequential mode, two of the three address lines change role. One becomes a serial enable and one becomes an asynchronous clear. The third address line is replaced by a full-flag output with its own output-enable. A write-busy output tells the scanner to blank the display while a qualifying write is in progress.

All bus inputs are sampled by the system clock through one register stage, and the strobe edges are found from that stage. The only exception is the clear, which acts without a clock.

Top module: `glyph_mem_writer`

## Requirements
- R1: After reset every entry reads 6'b100000 (blank), the write-busy output is low, the full output is low and its output-enable is low.
- R2: A write happens only when wr_n is low, sel_hi is high and sel_lo_n is low together. A strobe with either select inactive leaves the memory unchanged and does not raise write-busy.
- R3: In random mode (mode_pin captured as 0) the entry address is {shr2_in, shr1_in, shr0_in}, with shr0_in as the least significant bit. It is captured when the strobe turns on, and later changes on those lines during the same strobe have no effect.
- R4: The stored data is the value of bus_d when the strobe turns off. Earlier values of bus_d during the same strobe are not stored.
- R5: mode_pin is captured when the strobe turns on: 1 selects sequential mode and 0 selects random mode. The mode changes only at that point.
- R6: In sequential mode a qualifying write goes to the entry given by the counter, and the counter then advances by one. After a clear or a reset, the first entry written is entry 0.
- R7: In sequential mode, a strobe during which shr0_in (the serial enable) was low when the strobe turned on stores nothing and does not advance the counter.
- R8: In sequential mode the full flag rises after eight stored entries. While it is high, further strobes store nothing.
- R9: In sequential mode, shr1_in low clears the counter and the full flag and sets every entry to blank, without waiting for a clock edge. In random mode shr1_in low has no clearing effect.
- R10: shr2_oe is high only in sequential mode. It rises after the strobe that switches the block into sequential mode has turned off. It falls once a strobe that selects random mode has turned on. shr2_out carries the full flag and is low whenever shr2_oe is low.
- R11: wr_busy is high during a qualifying write, from shortly after the strobe turns on until shortly after it turns off. In sequential mode a write is qualifying only if the serial enable was high and the full flag was low when the strobe turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| bus_d | input | 6 | Character code |
| mode_pin | input | 1 | 1 = sequential, 0 = random |
| shr0_in | input | 1 | Address bit 0 (random) / serial enable (sequential) |
| shr1_in | input | 1 | Address bit 1 (random) / active-low clear (sequential) |
| shr2_in | input | 1 | Address bit 2 (random) |
| shr2_out | output | 1 | Full flag (sequential mode) |
| shr2_oe | output | 1 | Output-enable for the full flag |
| scan_addr | input | 3 | Scanner read address |
| scan_data | output | 6 | Entry at scan_addr |
| wr_busy | output | 1 | Qualifying write in progress; blanks the display |

## Verification
A counter that drifts or skips shows at the read port on the very next sequential write, because that write lands in the wrong entry. A counter that overruns shows as a full output that rises early, rises late, or never rises. A wrongly captured mode or address shows as data in the wrong entry, or as a full-flag output-enable that is wrong within two clocks after the strobe edge. A wrong qualify decision shows as wr_busy or as a stored entry that was expected to be blocked, within three clocks after the strobe turns on. A broken clear is visible at the full output within the same clock period.

// File: rtl/gmw_pkg.sv
package gmw_pkg;

  typedef enum logic {
    MODE_RAND = 1'b0,
    MODE_SEQ  = 1'b1
  } wmode_e;

  // Combined strobe: write low, high select high, low select low.
  function automatic logic strobe_on(input logic wr_n, input logic sel_hi, input logic sel_lo_n);
    return !wr_n && sel_hi && !sel_lo_n;
  endfunction

  // Decides at strobe turn-on whether the pending write may store.
  function automatic logic write_allowed(input logic seq, input logic sen, input logic full);
    return seq ? (sen && !full) : 1'b1;
  endfunction

endpackage

// File: rtl/gmw_strobe_sync.sv
module gmw_strobe_sync
  import gmw_pkg::*;
#(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic [DW-1:0] bus_d,
  input  logic          mode_pin,
  input  logic [2:0]    pins,
  output logic          en_s,
  output logic          en_d,
  output logic          fall_evt,
  output logic          rise_evt,
  output logic [DW-1:0] data_s,
  output logic          mode_s,
  output logic [2:0]    pin_s
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s   <= 1'b0;
      en_d   <= 1'b0;
      data_s <= '0;
      mode_s <= 1'b0;
      pin_s  <= '0;
    end else begin
      en_s   <= strobe_on(wr_n, sel_hi, sel_lo_n);
      en_d   <= en_s;
      data_s <= bus_d;
      mode_s <= mode_pin;
      pin_s  <= pins;
    end
  end

  // Strobe turn-on corresponds to the falling write edge, turn-off to the rising one.
  assign fall_evt = en_s && !en_d;
  assign rise_evt = !en_s && en_d;

endmodule

// File: rtl/gmw_ctrl.sv
module gmw_ctrl
  import gmw_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_act,
  input  logic          fall_evt,
  input  logic          rise_evt,
  input  logic          mode_s,
  input  logic [2:0]    pin_s,
  output wmode_e        mode_q,
  output logic [AW-1:0] wr_addr,
  output logic          wr_en,
  output logic          busy,
  output logic          full_flag,
  output logic          seq_out,
  output logic [CW-1:0] cnt
);

  logic [AW-1:0] addr_q;
  logic          act_q;
  logic          in_wr;

  assign full_flag = (cnt == CW'(DEPTH));

  // Latches taken at strobe turn-on; framing state cleared at turn-off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RAND;
      addr_q  <= '0;
      act_q   <= 1'b0;
      in_wr   <= 1'b0;
      seq_out <= 1'b0;
    end else if (fall_evt) begin
      mode_q <= wmode_e'(mode_s);
      addr_q <= AW'(pin_s);
      act_q  <= write_allowed(mode_s, pin_s[0], full_flag);
      in_wr  <= 1'b1;
      if (!mode_s) seq_out <= 1'b0;
    end else if (rise_evt) begin
      in_wr <= 1'b0;
      if (mode_q == MODE_SEQ) seq_out <= 1'b1;
    end
  end

  // Fill counter with an asynchronous clear from the shared pin.
  always_ff @(posedge clk or negedge rst_n or posedge clr_act) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_act) begin
      cnt <= '0;
    end else if (wr_en && (mode_q == MODE_SEQ)) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign wr_en   = rise_evt && act_q && ((mode_q == MODE_RAND) || !full_flag);
  assign wr_addr = (mode_q == MODE_SEQ) ? cnt[AW-1:0] : addr_q;
  assign busy    = in_wr && act_q;

endmodule

// File: rtl/gmw_store.sv
module gmw_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  localparam int AW = $clog2(DEPTH),
  localparam logic [DW-1:0] BLANK = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_act,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n or posedge clr_act) begin
      if (!rst_n) begin
        cells[g] <= BLANK;
      end else if (clr_act) begin
        cells[g] <= BLANK;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        cells[g] <= wr_data;
      end
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/glyph_mem_writer.sv
module glyph_mem_writer
  import gmw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic [DW-1:0] bus_d,
  input  logic          mode_pin,
  input  logic          shr0_in,
  input  logic          shr1_in,
  input  logic          shr2_in,
  output logic          shr2_out,
  output logic          shr2_oe,
  input  logic [AW-1:0] scan_addr,
  output logic [DW-1:0] scan_data,
  output logic          wr_busy
);

  logic          en_s_w, en_d_w, fall_w, rise_w;
  logic [DW-1:0] data_s_w;
  logic          mode_s_w;
  logic [2:0]    pin_s_w;
  wmode_e        mode_q;
  logic [AW-1:0] wr_addr_w;
  logic          wr_en_w, busy_w, full_w, seq_out_w;
  logic [CW-1:0] cnt_w;
  logic          mode_is_seq;
  logic          clr_act;

  gmw_strobe_sync #(.DW(DW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .bus_d    (bus_d),
    .mode_pin (mode_pin),
    .pins     ({shr2_in, shr1_in, shr0_in}),
    .en_s     (en_s_w),
    .en_d     (en_d_w),
    .fall_evt (fall_w),
    .rise_evt (rise_w),
    .data_s   (data_s_w),
    .mode_s   (mode_s_w),
    .pin_s    (pin_s_w)
  );

  assign mode_is_seq = (mode_q == MODE_SEQ);
  // Clear acts on the raw pin, without waiting for a clock.
  assign clr_act     = mode_is_seq && !shr1_in;

  gmw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_act   (clr_act),
    .fall_evt  (fall_w),
    .rise_evt  (rise_w),
    .mode_s    (mode_s_w),
    .pin_s     (pin_s_w),
    .mode_q    (mode_q),
    .wr_addr   (wr_addr_w),
    .wr_en     (wr_en_w),
    .busy      (busy_w),
    .full_flag (full_w),
    .seq_out   (seq_out_w),
    .cnt       (cnt_w)
  );

  gmw_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_act (clr_act),
    .wr_en   (wr_en_w),
    .wr_addr (wr_addr_w),
    .wr_data (data_s_w),
    .rd_addr (scan_addr),
    .rd_data (scan_data)
  );

  assign shr2_oe  = seq_out_w;
  assign shr2_out = seq_out_w && full_w;
  assign wr_busy  = busy_w;

endmodule

// File: rtl/gmw_checker.sv
module gmw_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_act,
  input logic          rise_evt,
  input logic          en_d,
  input logic          busy,
  input logic          wr_en,
  input logic          mode_is_seq,
  input logic          full_flag,
  input logic [CW-1:0] cnt,
  input logic          oe
);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_full_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    full_flag |=> $stable(cnt));

  p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    (wr_en && mode_is_seq) |=> (cnt == $past(cnt) + CW'(1)));

  p_rand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    (rise_evt && !mode_is_seq) |=> $stable(cnt));

  p_busy_in_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_d);

  p_busy_not_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_is_seq) |-> !full_flag);

  p_oe_seq_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> mode_is_seq);

endmodule

bind glyph_mem_writer gmw_checker #(.DEPTH(DEPTH)) u_gmw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_act     (clr_act),
  .rise_evt    (rise_w),
  .en_d        (en_d_w),
  .busy        (busy_w),
  .wr_en       (wr_en_w),
  .mode_is_seq (mode_is_seq),
  .full_flag   (full_w),
  .cnt         (cnt_w),
  .oe          (shr2_oe)
);

// File: tb/glyph_mem_writer_bench.sv
module glyph_mem_writer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr_n, sel_hi, sel_lo_n, mode_pin;
  logic       shr0_in, shr1_in, shr2_in;
  logic [5:0] bus_d;
  logic [2:0] scan_addr;
  logic       shr2_out, shr2_oe, wr_busy;
  logic [5:0] scan_data;

  glyph_mem_writer u_glyph_mem_writer (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .bus_d(bus_d), .mode_pin(mode_pin), .shr0_in(shr0_in), .shr1_in(shr1_in),
    .shr2_in(shr2_in), .shr2_out(shr2_out), .shr2_oe(shr2_oe),
    .scan_addr(scan_addr), .scan_data(scan_data), .wr_busy(wr_busy)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard of expected memory contents, consumed by the monitor.
  typedef struct {
    logic [2:0] a;
    logic [5:0] v;
    string      tag;
  } item_t;
  item_t exp_q[$];

  task automatic expect_cell(input logic [2:0] a, input logic [5:0] v, input string tag);
    item_t it;
    it.a = a; it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  item_t cur;
  always begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      scan_addr = cur.a;
      #1;
      chk($sformatf("%s cell%0d", cur.tag, cur.a), int'(scan_data), int'(cur.v));
    end
  end

  task automatic flush();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // One strobe. Pins and data change partway through the low phase.
  task automatic do_write(input logic md, input logic [2:0] p_fall, input logic [2:0] p_late,
                          input logic [5:0] d_early, input logic [5:0] d_final,
                          input logic sh, input logic sl_n,
                          input logic exp_busy, input logic exp_oe_low, input logic exp_oe_after,
                          input string req);
    @(negedge clk);
    mode_pin = md;
    {shr2_in, shr1_in, shr0_in} = p_fall;
    bus_d = d_early; sel_hi = sh; sel_lo_n = sl_n; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({req, " busy during strobe (R11)"}, int'(wr_busy), int'(exp_busy));
    chk({req, " oe during strobe (R10)"}, int'(shr2_oe), int'(exp_oe_low));
    {shr2_in, shr1_in, shr0_in} = p_late;
    mode_pin = ~md;
    bus_d = d_final;
    @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({req, " busy after strobe (R11)"}, int'(wr_busy), 0);
    chk({req, " oe after strobe (R10)"}, int'(shr2_oe), int'(exp_oe_after));
    sel_hi = 1'b1; sel_lo_n = 1'b0;
  endtask

  // Watchdog: an expired run counts as a failure and still prints the summary.
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0; mode_pin = 1'b0;
    shr0_in = 1'b0; shr1_in = 1'b1; shr2_in = 1'b0; bus_d = '0; scan_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(wr_busy), 0);
    chk("R1 oe", int'(shr2_oe), 0);
    chk("R1 full", int'(shr2_out), 0);
    for (int i = 0; i < 8; i++) expect_cell(3'(i), 6'h20, "R1");
    flush();

    // R3/R4/R5 random writes; address and data change during the strobe
    do_write(1'b0, 3'b101, 3'b010, 6'h11, 6'h2A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    do_write(1'b0, 3'b110, 3'b001, 6'h05, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    expect_cell(3'd5, 6'h2A, "R3 R4 addr latched");
    expect_cell(3'd2, 6'h20, "R3 late addr ignored");
    expect_cell(3'd6, 6'h3F, "R4 final data");
    flush();

    // R2 inactive selects
    do_write(1'b0, 3'b101, 3'b101, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 sel_hi");
    do_write(1'b0, 3'b101, 3'b101, 6'h01, 6'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 sel_lo_n");
    expect_cell(3'd5, 6'h2A, "R2 unchanged");
    flush();

    // R9 no clear in random mode
    shr1_in = 1'b0;
    repeat (2) @(negedge clk);
    shr1_in = 1'b1;
    expect_cell(3'd5, 6'h2A, "R9 random no clear");
    expect_cell(3'd6, 6'h3F, "R9 random no clear");
    flush();

    // R5/R6/R10 switch into sequential mode; first entry lands at 0
    do_write(1'b1, 3'b011, 3'b011, 6'h01, 6'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 switch");
    expect_cell(3'd0, 6'h01, "R6 first entry");
    flush();
    chk("R10 full low after switch", int'(shr2_out), 0);

    // R7 serial enable low
    do_write(1'b1, 3'b010, 3'b010, 6'h3A, 6'h3A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    expect_cell(3'd1, 6'h20, "R7 nothing stored");
    flush();

    // R6/R8 fill the remaining seven entries
    for (int k = 1; k < 8; k++) begin
      if (k == 7) chk("R8 full before eighth", int'(shr2_out), 0);
      do_write(1'b1, 3'b011, 3'b011, 6'h00, 6'(8'h10 + k), 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R6 fill");
    end
    chk("R8 full after eight", int'(shr2_out), 1);
    for (int k = 1; k < 8; k++) expect_cell(3'(k), 6'(8'h10 + k), "R6 order");
    flush();

    // R8 writes while full are ignored and do not raise busy
    do_write(1'b1, 3'b011, 3'b011, 6'h15, 6'h15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 blocked");
    expect_cell(3'd0, 6'h01, "R8 blocked");
    expect_cell(3'd7, 6'h17, "R8 blocked");
    flush();

    // R9 asynchronous clear in sequential mode
    @(negedge clk);
    #2 shr1_in = 1'b0;
    #1 chk("R9 full cleared without clock", int'(shr2_out), 0);
    repeat (2) @(negedge clk);
    shr1_in = 1'b1;
    for (int i = 0; i < 8; i++) expect_cell(3'(i), 6'h20, "R9 blank");
    flush();
    do_write(1'b1, 3'b011, 3'b011, 6'h00, 6'h33, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 restart");
    expect_cell(3'd0, 6'h33, "R9 counter at 0");
    expect_cell(3'd1, 6'h20, "R9 counter at 0");
    flush();

    // R10 back to random mode; output-enable drops while strobe is on
    do_write(1'b0, 3'b011, 3'b011, 6'h00, 6'h0C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 to random");
    chk("R10 full low in random", int'(shr2_out), 0);
    expect_cell(3'd3, 6'h0C, "R10 random addr");
    flush();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule